// File: doc/BRIEF.md
# Sequenced Boot Reply Packet Filter

This block sits on the receive side of a network boot path. Received packet words arrive one per cycle, already stripped of preamble and CRC-checked upstream. Each word carries a valid flag, and the last word of a packet also carries an end-of-packet flag. For every packet the block parses the fixed header and decides at end-of-packet whether to keep it. Payload words are sent to a memory write port at an advancing address while they arrive. Only an accepted packet moves the committed base address forward. A rejected packet leaves the base where it was, so its words are overwritten by the next packet.

A file is delivered as a numbered series of reply packets. The first packet must carry sequence number 1, and the block records that packet's inner source host. Every later packet must carry the next number in the series and come from the same host. A packet that is accepted and carries no data bytes ends the file. After that the block raises a sticky completion flag and ignores all further input.

Top module: `boot_reply_filter`

## Requirements
- R1: During and directly after a synchronous active-low reset, `wr_en`, `pkt_good` and `file_done` are low and the committed base address is zero.
- R2: Word positions count from 0 at the first word after the preamble. Words 0..2 and 12..14 must each equal the local host ID (word n+0 holds bits 47:32, n+1 holds bits 31:16, n+2 holds bits 15:0). Word 6 must be 0x0600, word 15 must be 65, word 22 must be 2, and word 25 must equal `file_num`. Any mismatch rejects the packet.
- R3: The following words have no effect on acceptance: words 3..5 (the outer source, which may be a gateway), 7, 9..11, 16..17, 21, 23 and 24.
- R4: Word 26 is the sequence number and words 18..20 are the inner source host. While no packet has been accepted, the sequence number must be 1 and any source host is taken. After that, the sequence number must be one more than the number of packets accepted so far, and the source host must equal the one from the first accepted packet.
- R5: Word 8 is a byte length. The payload is (length-40)/2 words, starting at word 27. A length below 40 rejects the packet. Words after the payload, up to end-of-packet, are discarded and not written.
- R6: Payload word k of a packet is written at committed base + k, with `wr_en` high in the cycle after the word is presented.
- R7: A packet is accepted when its end-of-packet word arrives at position 26 or later, with every header check passed, the full payload received and no receive error. `pkt_good` then pulses for one cycle, one cycle after that word. The base then advances by the payload word count rounded up to a multiple of 16.
- R8: If end-of-packet arrives before the declared payload is complete, the packet is rejected and the next packet's writes start at the unchanged base.
- R9: Any nonzero bit of `rx_err` on the end-of-packet word rejects the packet.
- R10: An accepted packet with length exactly 40 sets `file_done`, which stays set until reset. While it is set, no write and no `pkt_good` occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received word valid |
| rx_data | input | 16 | Received word |
| rx_eop | input | 1 | Marks the last word of a packet |
| rx_err | input | 4 | Receive error flags (alignment, overrun, bad packet, bad CRC), sampled on the last word |
| host_id | input | 48 | Local host ID |
| file_num | input | 16 | Requested file number |
| wr_en | output | 1 | Payload write strobe |
| wr_addr | output | ADDR_W | Payload write address |
| wr_data | output | 16 | Payload write data |
| pkt_good | output | 1 | One-cycle pulse per accepted packet |
| file_done | output | 1 | Sticky: empty packet accepted, file complete |

## Verification
Two functions can fall in the same cycle: the write of the last payload word and the verdict that commits or rolls back the base. This happens when end-of-packet lands on that payload word instead of on padding. The bench sends every odd-sized packet without padding, so the verdict and the final write coincide. It also sends truncated packets, whose end-of-packet word is itself a payload word. It judges the result by the address of the first write of the following accepted packet, which must equal the arithmetically computed base, and by comparing every stored word against the sent payload.

// File: rtl/bpf_pkg.sv
// Package: word positions and constants of the boot reply packet header.
// Assumes positions count from 0 at the first word after the preamble.
package bpf_pkg;
    localparam logic [15:0] IX_DST0  = 16'd0;
    localparam logic [15:0] IX_TYPE  = 16'd6;
    localparam logic [15:0] IX_LEN   = 16'd8;
    localparam logic [15:0] IX_DST1  = 16'd12;
    localparam logic [15:0] IX_SOCK  = 16'd15;
    localparam logic [15:0] IX_SRC   = 16'd18;
    localparam logic [15:0] IX_BTYPE = 16'd22;
    localparam logic [15:0] IX_FILE  = 16'd25;
    localparam logic [15:0] IX_SEQ   = 16'd26;
    localparam logic [15:0] IX_PAY   = 16'd27;

    localparam logic [15:0] TYPE_BOOT   = 16'h0600;
    localparam logic [15:0] SOCK_BOOT   = 16'd65;
    localparam logic [15:0] BTYPE_REPLY = 16'd2;
    localparam logic [15:0] OVH_BYTES   = 16'd40;

    // Pick one 16-bit word of a 48-bit host ID, most significant first.
    function automatic logic [15:0] host_word(input logic [47:0] h, input logic [1:0] k);
        case (k)
            2'd0:    host_word = h[47:32];
            2'd1:    host_word = h[31:16];
            default: host_word = h[15:0];
        endcase
    endfunction
endpackage

// File: rtl/bpf_field_check.sv
// Field check: decides, for one header word at a given position, whether it
// passes. Positions with no check always pass. Assumes the caller
// supplies the accepted-packet state (first flag, captured source, next seq).
module bpf_field_check
    import bpf_pkg::*;
(
    input  logic [15:0] idx,
    input  logic [15:0] data,
    input  logic [47:0] host_id,
    input  logic [15:0] file_num,
    input  logic [15:0] exp_seq,
    input  logic        first,
    input  logic [47:0] src_ref,
    output logic        ok
);
    // Compare the word with the value its position demands.
    always_comb begin
        ok = 1'b1;
        case (idx)
            IX_DST0, IX_DST0 + 16'd1, IX_DST0 + 16'd2:
                ok = (data == host_word(host_id, 2'(idx - IX_DST0)));
            IX_DST1, IX_DST1 + 16'd1, IX_DST1 + 16'd2:
                ok = (data == host_word(host_id, 2'(idx - IX_DST1)));
            IX_SRC, IX_SRC + 16'd1, IX_SRC + 16'd2:
                ok = first || (data == host_word(src_ref, 2'(idx - IX_SRC)));
            IX_TYPE:  ok = (data == TYPE_BOOT);
            IX_LEN:   ok = (data >= OVH_BYTES);
            IX_SOCK:  ok = (data == SOCK_BOOT);
            IX_BTYPE: ok = (data == BTYPE_REPLY);
            IX_FILE:  ok = (data == file_num);
            IX_SEQ:   ok = (data == exp_seq);
            default:  ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/bpf_addr_unit.sv
// Address unit: holds the committed base and forms write addresses as base
// plus the in-packet payload offset. On commit the base advances by the
// payload rounded up to a whole burst; without commit it never moves,
// which rolls back a rejected packet. Assumes ADDR_W <= 17.
module bpf_addr_unit #(
    parameter int ADDR_W    = 12,
    parameter int BURST_LG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [15:0]       pay_words,
    input  logic [15:0]       offset,
    output logic [ADDR_W-1:0] addr_now
);
    localparam int BURST = 1 << BURST_LG2;

    logic [ADDR_W-1:0] base_q;
    logic [16:0]       padded;
    logic [16:0]       rounded;

    // Round the payload word count up to a whole number of bursts.
    always_comb begin
        padded   = {1'b0, pay_words} + 17'(BURST - 1);
        rounded  = (padded >> BURST_LG2) << BURST_LG2;
        addr_now = base_q + ADDR_W'(offset);
    end

    // Advance the committed base only for an accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (commit) base_q <= base_q + ADDR_W'(rounded);
    end
endmodule

// File: rtl/boot_reply_filter.sv
// Top: word-serial filter for sequenced boot reply packets. It tracks the
// word position, runs the header checks, counts payload, writes payload
// words and gives a verdict at end-of-packet. Assumes preamble and CRC are
// handled upstream and rx_err is valid on the end-of-packet word.
module boot_reply_filter
    import bpf_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BURST_LG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [15:0]       rx_data,
    input  logic              rx_eop,
    input  logic [3:0]        rx_err,
    input  logic [47:0]       host_id,
    input  logic [15:0]       file_num,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              pkt_good,
    output logic              file_done
);
    logic [15:0]       idx_q, len_q, pay_cnt_q, pkt_cnt_q;
    logic              bad_q;
    logic [47:0]       src_stage_q, src_cap_q;
    logic              field_ok, hdr_bad, is_pay, accept, active, first;
    logic [15:0]       pay_words, pay_cnt_nx, exp_seq;
    logic [ADDR_W-1:0] addr_now;

    bpf_field_check u_field (
        .idx      (idx_q),
        .data     (rx_data),
        .host_id  (host_id),
        .file_num (file_num),
        .exp_seq  (exp_seq),
        .first    (first),
        .src_ref  (src_cap_q),
        .ok       (field_ok)
    );

    bpf_addr_unit #(.ADDR_W(ADDR_W), .BURST_LG2(BURST_LG2)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (active && accept),
        .pay_words (pay_words),
        .offset    (pay_cnt_q),
        .addr_now  (addr_now)
    );

    // Per-word decisions: payload membership and the end-of-packet verdict.
    always_comb begin
        active     = rx_valid && !file_done;
        first      = (pkt_cnt_q == 16'd0);
        exp_seq    = pkt_cnt_q + 16'd1;
        pay_words  = (len_q - OVH_BYTES) >> 1;
        hdr_bad    = bad_q || !field_ok;
        is_pay     = (idx_q >= IX_PAY) && (pay_cnt_q < pay_words);
        pay_cnt_nx = pay_cnt_q + {15'd0, is_pay};
        accept     = rx_eop && !hdr_bad && (idx_q >= IX_SEQ) &&
                     (pay_cnt_nx == pay_words) && (rx_err == 4'd0);
    end

    // Packet state, counters, source capture and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            len_q       <= '0;
            pay_cnt_q   <= '0;
            pkt_cnt_q   <= '0;
            bad_q       <= 1'b0;
            src_stage_q <= '0;
            src_cap_q   <= '0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            pkt_good    <= 1'b0;
            file_done   <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            pkt_good <= 1'b0;
            if (active) begin
                wr_en   <= is_pay && !hdr_bad;
                wr_addr <= addr_now;
                wr_data <= rx_data;
                if (rx_eop) begin
                    idx_q     <= '0;
                    bad_q     <= 1'b0;
                    pay_cnt_q <= '0;
                    if (accept) begin
                        pkt_good  <= 1'b1;
                        pkt_cnt_q <= pkt_cnt_q + 16'd1;
                        if (first) src_cap_q <= src_stage_q;
                        if (pay_words == 16'd0) file_done <= 1'b1;
                    end
                end else begin
                    if (idx_q != 16'hFFFF) idx_q <= idx_q + 16'd1;
                    bad_q     <= hdr_bad;
                    pay_cnt_q <= pay_cnt_nx;
                    if (idx_q == IX_LEN) len_q <= rx_data;
                    if (idx_q >= IX_SRC && idx_q <= IX_SRC + 16'd2)
                        src_stage_q <= {src_stage_q[31:0], rx_data};
                end
            end
        end
    end
endmodule

// File: rtl/bpf_checker.sv
// Checker: temporal properties of the filter's ports, bound to the top.
module bpf_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_eop,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              pkt_good,
    input logic              file_done
);
    // Verdict pulse follows an end-of-packet word.
    assert_good_after_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_good |-> $past(rx_valid && rx_eop));

    // Verdict pulse lasts one cycle.
    assert_good_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_good |=> !pkt_good);

    // Back-to-back writes go to consecutive addresses.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // Completion is sticky.
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        file_done |=> file_done);

    // No write once complete.
    assert_no_write_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        file_done |-> !wr_en);

    // No further verdict pulse once complete.
    assert_no_good_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (file_done && $past(file_done)) |-> !pkt_good);
endmodule

bind boot_reply_filter bpf_checker #(.ADDR_W(ADDR_W)) u_bpf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_eop    (rx_eop),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .pkt_good  (pkt_good),
    .file_done (file_done)
);

// File: tb/tb_boot_reply_filter.sv
module tb_boot_reply_filter;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int MEM_N      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [15:0]       rx_data = '0;
    logic              rx_eop = 1'b0;
    logic [3:0]        rx_err = '0;
    logic [47:0]       host_id = 48'h1234_5678_9ABC;
    logic [15:0]       file_num = 16'h0042;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    logic              pkt_good;
    logic              file_done;

    boot_reply_filter #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .rx_err(rx_err), .host_id(host_id), .file_num(file_num),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pkt_good(pkt_good), .file_done(file_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] mem [MEM_N];
    int          first_addr = -1;
    int          wr_count = 0;
    int          good_count = 0;
    int          exp_base = 0;
    logic [15:0] w [128];
    localparam logic [47:0] SRC = 48'hCAFE_0011_2233;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] hw(input logic [47:0] h, input int k);
        return (k == 0) ? h[47:32] : (k == 1) ? h[31:16] : h[15:0];
    endfunction

    function automatic logic [15:0] pay(input logic [15:0] seq, input int i);
        return (seq * 16'd257) ^ (16'(i) * 16'd3) ^ 16'h5A00;
    endfunction

    // Monitor outputs away from the active edge.
    always @(negedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            if (first_addr < 0) first_addr = int'(wr_addr);
            wr_count++;
        end
        if (pkt_good) good_count++;
    end

    // Mode: 0 good, 1 dst word, 2 second dst copy, 3 type, 4 socket,
    // 5 boot type, 6 file number, 7 truncated, 8 rx error, 9 short length.
    task automatic send(input logic [15:0] seq, input logic [47:0] src,
                        input int npay, input int mode);
        int total;
        int pad;
        logic [3:0] err;
        pad = (npay % 2 == 1) ? 0 : 3;
        err = 4'd0;
        for (int k = 0; k < 3; k++) begin
            w[k]      = hw(host_id, k);
            w[3 + k]  = seq ^ 16'(16'hA5A5 + k);
            w[12 + k] = hw(host_id, k);
            w[18 + k] = hw(src, k);
        end
        w[6] = 16'h0600;  w[7] = ~seq;  w[8] = 16'(40 + 2 * npay);
        w[9] = 16'h0009;  w[10] = seq;  w[11] = 16'h0007;
        w[15] = 16'd65;   w[16] = seq;  w[17] = ~seq;
        w[21] = 16'd10;   w[22] = 16'd2; w[23] = 16'hAA02; w[24] = seq;
        w[25] = file_num; w[26] = seq;
        for (int i = 0; i < npay + pad; i++)
            w[27 + i] = (i < npay) ? pay(seq, i) : 16'hDEAD;
        total = 27 + npay + pad;
        case (mode)
            1: w[1]  = w[1] ^ 16'h0001;
            2: w[13] = w[13] ^ 16'h0100;
            3: w[6]  = 16'h0601;
            4: w[15] = 16'd66;
            5: w[22] = 16'd1;
            6: w[25] = file_num + 16'd1;
            7: total = 27 + npay - 2;
            8: err   = 4'(1 << (seq % 4));
            9: w[8]  = 16'd38;
            default: ;
        endcase
        repeat (3) @(negedge clk);
        first_addr = -1;
        wr_count   = 0;
        good_count = 0;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = w[k];
            rx_eop   = (k == total - 1);
            rx_err   = (k == total - 1) ? err : 4'd0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eop = 1'b0; rx_err = 4'd0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_good(input logic [15:0] seq, input int npay, input string areq);
        bit ok_mem;
        chk(good_count == 1, "R3/R7 accept", good_count, 1);
        chk(wr_count == npay, "R5 write count", wr_count, npay);
        if (npay > 0)
            chk(first_addr == exp_base, areq, first_addr, exp_base);
        ok_mem = 1'b1;
        for (int i = 0; i < npay; i++)
            if (mem[(exp_base + i) % MEM_N] != pay(seq, i)) ok_mem = 1'b0;
        chk(ok_mem, "R6 stored payload", int'(ok_mem), 1);
        exp_base = (exp_base + ((npay + 15) / 16) * 16) % MEM_N;
    endtask

    task automatic expect_reject(input string req);
        chk(good_count == 0, req, good_count, 0);
    endtask

    string next_req;
    string rej_req [10] = '{"", "R2", "R2", "R2", "R2", "R2", "R2", "R8", "R9", "R5"};

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_en && !pkt_good && !file_done, "R1 reset outputs",
            int'({wr_en, pkt_good, file_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !pkt_good && !file_done, "R1 after reset",
            int'({wr_en, pkt_good, file_done}), 0);

        // First packet must carry sequence 1.
        send(16'd2, SRC, 4, 0);
        expect_reject("R4 first seq not 1");
        send(16'd1, SRC, 1, 0);
        expect_good(16'd1, 1, "R1 base zero / R4 first");

        for (int n = 2; n <= 33; n++) begin
            next_req = "R6 address";
            if (n % 3 == 0) begin
                int m;
                m = ((n / 3) % 9) + 1;
                send(16'(n), SRC, n, m);
                expect_reject(rej_req[m]);
                next_req = rej_req[m];
            end
            if (n == 10) begin
                send(16'(n), SRC ^ 48'h1, n, 0);
                expect_reject("R4 source mismatch");
                next_req = "R4";
            end
            if (n == 20) begin
                send(16'(n - 1), SRC, n, 0);
                expect_reject("R4 repeated seq");
                next_req = "R4";
            end
            if (n == 25) begin
                send(16'(n), SRC, n, 7);
                expect_reject("R8 truncated");
                next_req = "R8 rollback";
            end
            send(16'(n), SRC, n, 0);
            expect_good(16'(n), n, next_req);
        end

        chk(!file_done, "R10 not done yet", int'(file_done), 0);
        send(16'd34, SRC, 0, 0);
        chk(good_count == 1, "R10 empty accepted", good_count, 1);
        chk(file_done, "R10 done set", int'(file_done), 1);
        send(16'd35, SRC, 4, 0);
        chk(good_count == 0 && wr_count == 0, "R10 ignored after done",
            good_count + wr_count, 0);
        chk(file_done, "R10 done sticky", int'(file_done), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule